// File: doc/BRIEF.md
# Display Enable Window Sampler with Line Byte Counter

This block turns a horizontal window signal, produced by an upstream timing sequencer, into the display-enable signal used by a video memory fetch unit. The window signal may move at any cycle, but display-enable follows it only at a small set of fixed positions in the line. There are three positions where it may open, three where it may close, and one late position where an enable that is still open is cut. Because of this quantisation, a line fetches only certain byte counts, such as 0, 54, 160 or 230 bytes. Sync-scrolling software combines lines of these lengths.

Per line, the block counts the cycles in which display-enable is high and reports half that count as the number of fetched bytes, one byte per two cycles, when the line wraps. It also samples display-enable at a fixed detection position and issues a one-cycle load strobe at a fixed later position. A first-pixel strobe follows the load strobe after a fixed pipeline delay. A line-wrap input marks the final cycle of each line, so lines of any length (508 or 512 cycles, for example) are handled the same way.

Top module: `de_window_sampler`

## Requirements
- R1: While reset is held, and in the first cycle after it, de_o, load_o, pix_first_o and bytes_vld_o are 0.
- R2: If h_win_i is 1 in a cycle where line_cyc_i is 8, 56 or 60 and line_wrap_i is 0, de_o is 1 in the following cycle.
- R3: If h_win_i is 0 in a cycle where line_cyc_i is 168, 376 or 380 and line_wrap_i is 0, de_o is 0 in the following cycle.
- R4: If h_win_i is 1 in a cycle where line_cyc_i is 468, de_o is 0 in the following cycle.
- R5: In any cycle where line_cyc_i is none of the positions in R2, R3 or R4 and line_wrap_i is 0, h_win_i has no effect: de_o keeps its value into the next cycle.
- R6: line_wrap_i is high during the final cycle of a line. In the next cycle de_o is 0, even if the window never closed it.
- R7: In the cycle after line_wrap_i is high, bytes_vld_o pulses for one cycle. bytes_o then equals the number of cycles of the line just ended (the wrap cycle included) with de_o high, divided by two and rounded down. For example, enable opened at 60 and closed at 380 gives 160, opened at 8 and cut at 468 gives 230, and never opened gives 0.
- R8: load_o is 1 for exactly the cycle after the one where line_cyc_i is 64, and only if de_o was 1 during the cycle where line_cyc_i was 62 on the same line.
- R9: pix_first_o is 1 exactly 17 cycles after each cycle in which load_o is 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cyc_i | input | 9 | Cycle position within the current line |
| h_win_i | input | 1 | Horizontal window from the timing sequencer |
| line_wrap_i | input | 1 | High during the last cycle of a line |
| de_o | output | 1 | Quantised display-enable |
| load_o | output | 1 | One-cycle strobe starting pixel delivery |
| pix_first_o | output | 1 | One-cycle strobe marking the first pixel value |
| bytes_o | output | 9 | Bytes fetched on the line just ended |
| bytes_vld_o | output | 1 | bytes_o is valid this cycle |

## Verification
The collision that matters is a line wrap arriving while display-enable is still open. This happens when the window drops between the last close position and the cut position, so nothing closes the enable. In that same cycle the enable is forced low, the count of the ending line is reported including the wrap cycle, and the accumulator restarts. The bench provokes this with a window that falls at cycle 400, with lines of 508 and 512 cycles, and with a pseudo-random window that toggles across every sample position. A behavioural reference model predicts the reported count (227 bytes for a 512-cycle line opened at 56) and that display-enable is low in the first cycle of the next line.

// File: rtl/desamp_pkg.sv
package desamp_pkg;

   typedef enum logic [1:0] {
      DE_HOLD = 2'd0,
      DE_OPEN = 2'd1,
      DE_SHUT = 2'd2
   } de_act_e;

endpackage

// File: rtl/desamp_gate.sv
module desamp_gate
   import desamp_pkg::*;
#(
   parameter int unsigned CYC_W    = 9,
   parameter int unsigned N_OPEN   = 3,
   parameter int unsigned N_CLOSE  = 3,
   parameter int unsigned OPEN_POS  [N_OPEN]  = '{8, 56, 60},
   parameter int unsigned CLOSE_POS [N_CLOSE] = '{168, 376, 380},
   parameter int unsigned CUT_POS  = 468
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CYC_W-1:0] cyc_i,
   input  logic             h_i,
   input  logic             wrap_i,
   output logic             de_o
);

   logic [N_OPEN-1:0]  open_hit;
   logic [N_CLOSE-1:0] close_hit;
   logic               cut_hit;
   de_act_e            act;
   logic               de_q;

   for (genvar gi = 0; gi < N_OPEN; gi++) begin : g_open
      if (OPEN_POS[gi] >= (1 << CYC_W)) begin : g_bad
         $error("open position beyond counter range");
      end
      assign open_hit[gi] = (cyc_i == CYC_W'(OPEN_POS[gi]));
   end

   for (genvar gj = 0; gj < N_CLOSE; gj++) begin : g_close
      if (CLOSE_POS[gj] >= (1 << CYC_W)) begin : g_bad
         $error("close position beyond counter range");
      end
      assign close_hit[gj] = (cyc_i == CYC_W'(CLOSE_POS[gj]));
   end

   if (CUT_POS >= (1 << CYC_W)) begin : g_bad_cut
      $error("cut position beyond counter range");
   end
   assign cut_hit = (cyc_i == CYC_W'(CUT_POS));

   always_comb begin
      act = DE_HOLD;
      if (wrap_i)                  act = DE_SHUT;
      else if (cut_hit && h_i)     act = DE_SHUT;
      else if ((|close_hit) && !h_i) act = DE_SHUT;
      else if ((|open_hit) && h_i) act = DE_OPEN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             de_q <= 1'b0;
      else if (act == DE_OPEN) de_q <= 1'b1;
      else if (act == DE_SHUT) de_q <= 1'b0;
   end

   assign de_o = de_q;

   a_r2_rise_needs_window : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de_q) |-> $past(h_i) && !$past(wrap_i));

   a_r4_cut_closes : assert property (@(posedge clk) disable iff (!rst_n)
      (cut_hit && h_i) |=> !de_q);

   a_r5_hold_elsewhere : assert property (@(posedge clk) disable iff (!rst_n)
      (!(|open_hit) && !(|close_hit) && !cut_hit && !wrap_i) |=> $stable(de_q));

   a_r6_wrap_clears : assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> !de_q);

endmodule

// File: rtl/desamp_bytecnt.sv
module desamp_bytecnt #(
   parameter int unsigned CYC_W  = 9,
   parameter int unsigned BYTE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              de_i,
   input  logic              wrap_i,
   output logic [BYTE_W-1:0] bytes_o,
   output logic              vld_o
);

   localparam int unsigned ACC_W = CYC_W + 1;

   if (BYTE_W < CYC_W) begin : g_bad_w
      $error("byte count too narrow for a full line");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] half;

   assign acc_sum = acc_q + ACC_W'(de_i);
   assign half    = acc_sum >> 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         bytes_o <= '0;
         vld_o   <= 1'b0;
      end else if (wrap_i) begin
         acc_q   <= '0;
         bytes_o <= BYTE_W'(half);
         vld_o   <= 1'b1;
      end else begin
         acc_q   <= acc_sum;
         vld_o   <= 1'b0;
      end
   end

   a_r7_report_after_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> $past(wrap_i));

   a_r7_wrap_reports : assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> vld_o);

   a_r7_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (bytes_o <= BYTE_W'(1 << (CYC_W - 1))));

endmodule

// File: rtl/desamp_loadseq.sv
module desamp_loadseq #(
   parameter int unsigned CYC_W     = 9,
   parameter int unsigned DET_POS   = 62,
   parameter int unsigned LOAD_POS  = 64,
   parameter int unsigned PIX_DELAY = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CYC_W-1:0] cyc_i,
   input  logic             de_i,
   input  logic             wrap_i,
   output logic             load_o,
   output logic             pix_o
);

   if (DET_POS >= LOAD_POS) begin : g_bad_order
      $error("detection must precede load");
   end

   logic det_q;
   logic load_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det_q  <= 1'b0;
         load_q <= 1'b0;
      end else begin
         if (wrap_i)                          det_q <= 1'b0;
         else if (cyc_i == CYC_W'(DET_POS))   det_q <= de_i;
         load_q <= !wrap_i && det_q && (cyc_i == CYC_W'(LOAD_POS));
      end
   end

   assign load_o = load_q;

   if (PIX_DELAY == 0) begin : g_nodelay
      assign pix_o = load_q;
   end else begin : g_delay
      logic [PIX_DELAY-1:0] pipe_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[PIX_DELAY-2+((PIX_DELAY==1)?1:0):0] & {(PIX_DELAY>1?PIX_DELAY-1:1){PIX_DELAY>1}}, load_q} & PIX_DELAY'({PIX_DELAY{1'b1}});
      end
      assign pix_o = pipe_q[PIX_DELAY-1];
   end

   a_r8_load_position : assert property (@(posedge clk) disable iff (!rst_n)
      load_q |-> ($past(cyc_i) == CYC_W'(LOAD_POS)));

   a_r8_load_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      load_q |=> !load_q);

endmodule

// File: rtl/de_window_sampler.sv
module de_window_sampler
   import desamp_pkg::*;
#(
   parameter int unsigned MAX_LINE  = 512,
   parameter int unsigned CUT_POS   = 468,
   parameter int unsigned DET_POS   = 62,
   parameter int unsigned LOAD_POS  = 64,
   parameter int unsigned PIX_DELAY = 17,
   parameter int unsigned CYC_W     = $clog2(MAX_LINE),
   parameter int unsigned BYTE_W    = $clog2(MAX_LINE / 2 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CYC_W-1:0]  line_cyc_i,
   input  logic              h_win_i,
   input  logic              line_wrap_i,
   output logic              de_o,
   output logic              load_o,
   output logic              pix_first_o,
   output logic [BYTE_W-1:0] bytes_o,
   output logic              bytes_vld_o
);

   localparam int unsigned N_OPEN  = 3;
   localparam int unsigned N_CLOSE = 3;
   localparam int unsigned OPEN_SET  [N_OPEN]  = '{8, 56, 60};
   localparam int unsigned CLOSE_SET [N_CLOSE] = '{168, 376, 380};

   if (MAX_LINE < 2) begin : g_bad_len
      $error("line length too small");
   end
   if (CUT_POS >= MAX_LINE) begin : g_bad_cut
      $error("cut position beyond line length");
   end

   logic de_w;

   desamp_gate #(
      .CYC_W    (CYC_W),
      .N_OPEN   (N_OPEN),
      .N_CLOSE  (N_CLOSE),
      .OPEN_POS (OPEN_SET),
      .CLOSE_POS(CLOSE_SET),
      .CUT_POS  (CUT_POS)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc_i (line_cyc_i),
      .h_i   (h_win_i),
      .wrap_i(line_wrap_i),
      .de_o  (de_w)
   );

   desamp_bytecnt #(
      .CYC_W (CYC_W),
      .BYTE_W(BYTE_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .de_i   (de_w),
      .wrap_i (line_wrap_i),
      .bytes_o(bytes_o),
      .vld_o  (bytes_vld_o)
   );

   desamp_loadseq #(
      .CYC_W    (CYC_W),
      .DET_POS  (DET_POS),
      .LOAD_POS (LOAD_POS),
      .PIX_DELAY(PIX_DELAY)
   ) u_load (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc_i (line_cyc_i),
      .de_i  (de_w),
      .wrap_i(line_wrap_i),
      .load_o(load_o),
      .pix_o (pix_first_o)
   );

   assign de_o = de_w;

   a_r1_quiet_after_reset : assert property (@(posedge clk)
      $rose(rst_n) |-> !de_o && !load_o && !pix_first_o && !bytes_vld_o);

endmodule

// File: tb/de_window_sampler_tb_top.sv
module de_window_sampler_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] line_cyc_i = '0;
   logic       h_win_i = 1'b0;
   logic       line_wrap_i = 1'b0;
   logic       de_o, load_o, pix_first_o, bytes_vld_o;
   logic [8:0] bytes_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   de_window_sampler dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_cyc_i (line_cyc_i),
      .h_win_i    (h_win_i),
      .line_wrap_i(line_wrap_i),
      .de_o       (de_o),
      .load_o     (load_o),
      .pix_first_o(pix_first_o),
      .bytes_o    (bytes_o),
      .bytes_vld_o(bytes_vld_o)
   );

   // behavioural reference state
   bit    m_de, m_det, m_load, m_pix, m_vld;
   int    m_acc, m_bytes, m_tick;
   int    pix_due[$];
   string de_tag = "R1";
   bit [15:0] lfsr = 16'hACE1;

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      check(de_tag, de_o, m_de, "de_o");
      check("R8", load_o, m_load, "load_o");
      check("R9", pix_first_o, m_pix, "pix_first_o");
      check("R7", bytes_vld_o, m_vld, "bytes_vld_o");
      if (m_vld) check("R7", bytes_o, m_bytes, "bytes_o");
   endtask

   function automatic bit is_open(int c);
      return c == 8 || c == 56 || c == 60;
   endfunction

   function automatic bit is_close(int c);
      return c == 168 || c == 376 || c == 380;
   endfunction

   task automatic drive(int cyc, bit h, bit wrap);
      bit nde, ndet;
      @(negedge clk);
      compare();
      line_cyc_i  = 9'(cyc);
      h_win_i     = h;
      line_wrap_i = wrap;
      // predict the state after the coming edge
      nde = m_de;
      if (wrap)                    begin nde = 0; de_tag = "R6"; end
      else if (cyc == 468 && h)    begin nde = 0; de_tag = "R4"; end
      else if (is_close(cyc) && !h) begin nde = 0; de_tag = "R3"; end
      else if (is_open(cyc) && h)  begin nde = 1; de_tag = "R2"; end
      else                         de_tag = "R5";
      if (wrap) begin
         m_bytes = (m_acc + int'(m_de)) / 2;
         m_vld   = 1;
         m_acc   = 0;
      end else begin
         m_acc = m_acc + int'(m_de);
         m_vld = 0;
      end
      ndet   = wrap ? 1'b0 : (cyc == 62 ? m_de : m_det);
      m_load = !wrap && cyc == 64 && m_det;
      m_tick++;
      if (m_load) pix_due.push_back(m_tick + 17);
      m_pix = 0;
      if (pix_due.size() > 0 && pix_due[0] == m_tick) begin
         m_pix = 1;
         void'(pix_due.pop_front());
      end
      m_de  = nde;
      m_det = ndet;
   endtask

   task automatic run_line(int len, int on, int off, bit rnd);
      for (int c = 0; c < len; c++) begin
         bit h;
         if (rnd) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            h = lfsr[0];
         end else begin
            h = (c >= on) && (c < off);
         end
         drive(c, h, c == len - 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      check("R1", de_o, 0, "de_o in reset");
      check("R1", load_o, 0, "load_o in reset");
      check("R1", pix_first_o, 0, "pix_first_o in reset");
      check("R1", bytes_vld_o, 0, "bytes_vld_o in reset");
      rst_n = 1'b1;
      run_line(512, 58, 378, 0);   // R7: 160 bytes
      run_line(512, 0, 600, 0);    // R4: cut at 468, 230 bytes
      run_line(512, 0, 0, 0);      // never opened, 0 bytes
      run_line(512, 58, 100, 0);   // 54 bytes
      run_line(512, 50, 400, 0);   // R6: still open at wrap, 227 bytes
      run_line(508, 50, 400, 0);   // shorter line with the same collision
      run_line(512, 9, 167, 0);    // R5: edges between positions
      run_line(508, 0, 170, 0);
      for (int k = 0; k < 6; k++) run_line(512, 0, 0, 1);
      for (int k = 0; k < 30; k++) drive(0, 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule